// File: doc/BRIEF.md
# Signature-Indexed Reuse Predictor

This block tells a cache's replacement logic which re-reference value to give a line, so that lines brought in by access streams that seldom come back (scans) are inserted near eviction. Each access carries a signature made elsewhere, for example a hash of the requesting instruction address. The signature is folded down to a table index. That index selects a 2-bit saturating counter, which records whether lines inserted under that signature were used again before they left the cache.

Training happens only when a line leaves the cache. A small sample of sets keeps per-line metadata for this: a valid flag, a reuse flag, and the table index of the fill that brought the line in. When a sampled line is evicted, its reuse flag moves the stored counter up or down. All other sets receive predictions but do not train. For each access the block returns a 2-bit prediction one cycle later. A hit gets the immediate value. A miss gets the distant value when its counter is zero and the far value otherwise.

Top module: `sigreuse_predictor`

## Requirements
- R1: `pred_valid` is high in the cycle after each cycle with `acc_valid` high, and low after each cycle with `acc_valid` low, including the first cycle after reset.
- R2: When `acc_hit` is high, the prediction is 0 (immediate), whatever the counter holds.
- R3: When `acc_hit` is low, the prediction is 3 (distant) if the counter selected by the access is 0, and 2 (far) if that counter is nonzero.
- R4: Every counter comes out of reset at 1, so a signature that has never trained gets the far prediction on a miss.
- R5: Evicting a tracked, valid line whose reuse flag is set increments the counter at the line's stored index, and the counter stays at 3 once it is there.
- R6: Evicting a tracked, valid line whose reuse flag is clear decrements the counter at the line's stored index, and the counter stays at 0 once it is there.
- R7: A miss (fill) on a tracked line marks it valid, clears its reuse flag and stores the current index. A hit on a valid tracked line sets its reuse flag. Hits never change a counter.
- R8: A set is tracked when its low `SET_W-SMP_AW` index bits are all zero. Fills, hits and evictions on other sets never change any counter.
- R9: The counter index is the XOR fold of the signature: index bit k is the XOR of every signature bit i with i mod `TBL_AW` = k. Signatures with equal folds share one counter.
- R10: When an eviction updates the same counter that an access reads in the same cycle, the prediction uses the counter value from before the update.
- R11: Evicting a tracked line that is not valid (never filled since reset, or already evicted and not filled again) changes no counter. Every eviction of a tracked line clears its valid flag.
- R12: When an eviction and a fill name the same tracked line in the same cycle, training uses the line's old metadata and the line keeps the new fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access event present this cycle |
| acc_hit | input | 1 | 1 = hit, 0 = miss that fills the named way |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way hit or filled |
| acc_sig | input | SIG_W | Signature of the access |
| evict_valid | input | 1 | Eviction event present this cycle |
| evict_set | input | SET_W | Set index of the evicted line |
| evict_way | input | WAY_W | Way of the evicted line |
| pred_valid | output | 1 | Prediction for the previous cycle's access is present |
| pred_rrpv | output | 2 | Re-reference prediction (0 immediate, 2 far, 3 distant) |

## Verification
The bench builds the block with `TBL_AW=3`, `SET_W=4`, `WAY_W=2` and `SMP_AW=2`, and keeps the 14-bit signature. That gives eight counters, each of which reaches both saturation limits within a few evictions. The 14-bit signature folds onto only eight entries, so aliasing shows up often. One set in four is tracked, so untracked traffic is mixed in with tracked traffic. The sixteen tracked lines are few enough that a long random stream fills, hits and evicts every one of them many times, including same-cycle collisions between eviction, fill and prediction reads.

// File: rtl/sigreuse_pkg.sv
package sigreuse_pkg;
  typedef logic [1:0] rrpv_t;
  typedef logic [1:0] ctr_t;

  localparam rrpv_t RRPV_IMMEDIATE = 2'd0;
  localparam rrpv_t RRPV_FAR       = 2'd2;
  localparam rrpv_t RRPV_DISTANT   = 2'd3;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;
endpackage

// File: rtl/sigreuse_ctr_table.sv
module sigreuse_ctr_table
  import sigreuse_pkg::*;
#(
  parameter int TBL_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TBL_AW-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              train_en,
  input  logic              train_up,
  input  logic [TBL_AW-1:0] train_idx
);
  localparam int DEPTH = 2 ** TBL_AW;

  logic [2*DEPTH-1:0] ctr_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    ctr_t ctr_q;
    ctr_t ctr_d;
    logic wr_en;

    assign wr_en = train_en && (train_idx == TBL_AW'(g));

    always_comb begin
      ctr_d = ctr_q;
      if (train_up) begin
        if (ctr_q != CTR_MAX) ctr_d = ctr_q + 2'd1;
      end else begin
        if (ctr_q != CTR_MIN) ctr_d = ctr_q - 2'd1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctr_q <= CTR_INIT;
      else if (wr_en) ctr_q <= ctr_d;
    end

    assign ctr_flat[2*g +: 2] = ctr_q;
  end

  // Read returns the stored value; an update in the same cycle lands at the edge.
  assign rd_ctr = ctr_flat[2*rd_idx +: 2];
endmodule

// File: rtl/sigreuse_line_meta.sv
module sigreuse_line_meta #(
  parameter int IDX_W  = 11,
  parameter int SET_W  = 11,
  parameter int WAY_W  = 4,
  parameter int SMP_AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             evict_valid,
  input  logic [SET_W-1:0] evict_set,
  input  logic [WAY_W-1:0] evict_way,
  output logic             train_en,
  output logic             train_up,
  output logic [IDX_W-1:0] train_idx
);
  localparam int STRIDE_W = SET_W - SMP_AW;
  localparam int LINE_AW  = SMP_AW + WAY_W;
  localparam int LINES    = 2 ** LINE_AW;

  logic               acc_samp, ev_samp;
  logic [LINE_AW-1:0] acc_line, ev_line;
  logic [LINES-1:0]   valid_vec, reuse_vec;
  logic [LINES*IDX_W-1:0] idx_vec;

  if (STRIDE_W > 0) begin : g_strided
    assign acc_samp = (acc_set[STRIDE_W-1:0] == '0);
    assign ev_samp  = (evict_set[STRIDE_W-1:0] == '0);
  end else begin : g_all
    assign acc_samp = 1'b1;
    assign ev_samp  = 1'b1;
  end

  assign acc_line = {acc_set[SET_W-1:STRIDE_W], acc_way};
  assign ev_line  = {evict_set[SET_W-1:STRIDE_W], evict_way};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic             v_q, r_q, v_d, r_d;
    logic [IDX_W-1:0] i_q;
    logic             acc_m, ev_m, fill_m, upd_en;

    assign acc_m  = acc_valid && acc_samp && (acc_line == LINE_AW'(g));
    assign ev_m   = evict_valid && ev_samp && (ev_line == LINE_AW'(g));
    assign fill_m = acc_m && !acc_hit;
    assign upd_en = acc_m || ev_m;

    always_comb begin
      v_d = v_q;
      r_d = r_q;
      if (ev_m) v_d = 1'b0;
      if (acc_m && acc_hit && v_q) r_d = 1'b1;
      if (fill_m) begin
        v_d = 1'b1;
        r_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        r_q <= 1'b0;
      end else if (upd_en) begin
        v_q <= v_d;
        r_q <= r_d;
      end
    end

    // Index storage is only read while the valid flag is set; no reset needed.
    always_ff @(posedge clk) begin
      if (fill_m) i_q <= acc_idx;
    end

    assign valid_vec[g]             = v_q;
    assign reuse_vec[g]             = r_q;
    assign idx_vec[g*IDX_W +: IDX_W] = i_q;
  end

  assign train_en  = evict_valid && ev_samp && valid_vec[ev_line];
  assign train_up  = reuse_vec[ev_line];
  assign train_idx = idx_vec[ev_line*IDX_W +: IDX_W];
endmodule

// File: rtl/sigreuse_predictor.sv
module sigreuse_predictor
  import sigreuse_pkg::*;
#(
  parameter int SIG_W  = 14,
  parameter int TBL_AW = 11,
  parameter int SET_W  = 11,
  parameter int WAY_W  = 4,
  parameter int SMP_AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SIG_W-1:0] acc_sig,
  input  logic             evict_valid,
  input  logic [SET_W-1:0] evict_set,
  input  logic [WAY_W-1:0] evict_way,
  output logic             pred_valid,
  output logic [1:0]       pred_rrpv
);
  function automatic logic [TBL_AW-1:0] fold_sig(input logic [SIG_W-1:0] s);
    logic [TBL_AW-1:0] r;
    r = '0;
    for (int i = 0; i < SIG_W; i++) r[i % TBL_AW] = r[i % TBL_AW] ^ s[i];
    return r;
  endfunction

  logic [TBL_AW-1:0] acc_idx, train_idx;
  logic              train_en, train_up;
  ctr_t              rd_ctr;
  logic              pred_valid_q;
  rrpv_t             pred_rrpv_q, pred_rrpv_d;

  assign acc_idx = fold_sig(acc_sig);

  sigreuse_ctr_table #(.TBL_AW(TBL_AW)) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (acc_idx),
    .rd_ctr    (rd_ctr),
    .train_en  (train_en),
    .train_up  (train_up),
    .train_idx (train_idx)
  );

  sigreuse_line_meta #(
    .IDX_W (TBL_AW),
    .SET_W (SET_W),
    .WAY_W (WAY_W),
    .SMP_AW(SMP_AW)
  ) meta_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_hit     (acc_hit),
    .acc_set     (acc_set),
    .acc_way     (acc_way),
    .acc_idx     (acc_idx),
    .evict_valid (evict_valid),
    .evict_set   (evict_set),
    .evict_way   (evict_way),
    .train_en    (train_en),
    .train_up    (train_up),
    .train_idx   (train_idx)
  );

  always_comb begin
    pred_rrpv_d = pred_rrpv_q;
    if (acc_valid) begin
      if (acc_hit)              pred_rrpv_d = RRPV_IMMEDIATE;
      else if (rd_ctr == CTR_MIN) pred_rrpv_d = RRPV_DISTANT;
      else                      pred_rrpv_d = RRPV_FAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid_q <= 1'b0;
      pred_rrpv_q  <= RRPV_IMMEDIATE;
    end else begin
      pred_valid_q <= acc_valid;
      if (acc_valid) pred_rrpv_q <= pred_rrpv_d;
    end
  end

  assign pred_valid = pred_valid_q;
  assign pred_rrpv  = pred_rrpv_q;
endmodule

// File: rtl/sigreuse_chk.sv
module sigreuse_chk #(
  parameter int SET_W  = 11,
  parameter int SMP_AW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_hit,
  input logic             evict_valid,
  input logic [SET_W-1:0] evict_set,
  input logic             pred_valid,
  input logic [1:0]       pred_rrpv,
  input logic             train_en
);
  localparam int STRIDE_W = SET_W - SMP_AW;
  localparam logic [SET_W-1:0] LOW_MASK = SET_W'((1 << STRIDE_W) - 1);

  logic ev_tracked;
  assign ev_tracked = ((evict_set & LOW_MASK) == '0);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> pred_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !pred_valid);

  p_hit_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> (pred_rrpv == 2'd0));

  p_miss_far_or_distant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=> pred_rrpv[1]);

  p_untracked_no_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_valid && !ev_tracked) |-> !train_en);

  p_train_needs_evict_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |-> !train_en);
endmodule

bind sigreuse_predictor sigreuse_chk #(.SET_W(SET_W), .SMP_AW(SMP_AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_hit     (acc_hit),
  .evict_valid (evict_valid),
  .evict_set   (evict_set),
  .pred_valid  (pred_valid),
  .pred_rrpv   (pred_rrpv),
  .train_en    (train_en)
);

// File: tb/sigreuse_predictor_tb_top.sv
`timescale 1ns/1ps
module sigreuse_predictor_tb_top;
  localparam int SIG_W  = 14;
  localparam int TBL_AW = 3;
  localparam int SET_W  = 4;
  localparam int WAY_W  = 2;
  localparam int SMP_AW = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_valid, acc_hit, evict_valid;
  logic [SET_W-1:0] acc_set, evict_set;
  logic [WAY_W-1:0] acc_way, evict_way;
  logic [SIG_W-1:0] acc_sig;
  logic             pred_valid;
  logic [1:0]       pred_rrpv;

  int n_chk  = 0;
  int n_fail = 0;

  int       m_ctr [8];
  bit       m_v   [4][4];
  bit       m_r   [4][4];
  int       m_idx [4][4];

  always #5 clk = ~clk;

  sigreuse_predictor #(
    .SIG_W(SIG_W), .TBL_AW(TBL_AW), .SET_W(SET_W), .WAY_W(WAY_W), .SMP_AW(SMP_AW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_set(acc_set),
    .acc_way(acc_way), .acc_sig(acc_sig),
    .evict_valid(evict_valid), .evict_set(evict_set), .evict_way(evict_way),
    .pred_valid(pred_valid), .pred_rrpv(pred_rrpv)
  );

  function automatic int fold(input int s);
    int r = 0;
    for (int i = 0; i < SIG_W; i++)
      if ((s >> i) & 1) r = r ^ (1 << (i % TBL_AW));
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit av, input bit hit, input int set, input int way, input int sig,
                      input bit ev, input int es, input int ew, input string tag);
    int  exp_r, s, ti;
    bit  old_v;
    string t;
    @(negedge clk);
    acc_valid   = av;  acc_hit = hit;
    acc_set     = SET_W'(set); acc_way = WAY_W'(way); acc_sig = SIG_W'(sig);
    evict_valid = ev;  evict_set = SET_W'(es); evict_way = WAY_W'(ew);
    exp_r = hit ? 0 : ((m_ctr[fold(sig)] == 0) ? 3 : 2);
    // model: training from old metadata, then metadata update (R5 R6 R7 R11 R12)
    if (ev && (es % 4) == 0) begin
      s = es / 4;
      if (m_v[s][ew]) begin
        ti = m_idx[s][ew];
        if (m_r[s][ew]) begin if (m_ctr[ti] < 3) m_ctr[ti]++; end
        else            begin if (m_ctr[ti] > 0) m_ctr[ti]--; end
      end
    end
    if (av && (set % 4) == 0) begin
      s = set / 4;
      old_v = m_v[s][way];
      if (hit) begin if (old_v) m_r[s][way] = 1; end
      else begin m_v[s][way] = 1; m_r[s][way] = 0; m_idx[s][way] = fold(sig); end
    end
    if (ev && (es % 4) == 0 && !(av && !hit && set == es && way == ew)) m_v[es/4][ew] = 0;
    @(posedge clk); #1;
    check(pred_valid == av, "R1 pred_valid", int'(pred_valid), int'(av));
    if (av) begin
      t = (tag != "") ? tag : (hit ? "R2" : "R3");
      check(int'(pred_rrpv) == exp_r, t, int'(pred_rrpv), exp_r);
    end
  endtask

  task automatic fill(input int set, input int way, input int sig, input string tag);
    step(1, 0, set, way, sig, 0, 0, 0, tag);
  endtask
  task automatic hitl(input int set, input int way, input int sig, input string tag);
    step(1, 1, set, way, sig, 0, 0, 0, tag);
  endtask
  task automatic evict(input int set, input int way);
    step(0, 0, 0, 0, 0, 1, set, way, "");
  endtask
  task automatic probe(input int sig, input string tag);
    step(1, 0, 1, 0, sig, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_ctr[i] = 1;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_r[s][w] = 0; m_idx[s][w] = 0; end
    rst_n = 1'b0;
    acc_valid = 0; acc_hit = 0; acc_set = '0; acc_way = '0; acc_sig = '0;
    evict_valid = 0; evict_set = '0; evict_way = '0;
    repeat (3) @(posedge clk);
    #1 check(pred_valid == 1'b0, "R1 reset", int'(pred_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R4: untrained signature predicts far
    probe(5, "R4");
    // R6: non-reused eviction, then saturation at 0
    fill(0, 0, 5, "R4");
    evict(0, 0);
    probe(5, "R6");
    fill(0, 0, 5, "R6");
    evict(0, 0);
    probe(5, "R6");
    // R11: eviction of never-filled and already-evicted lines
    evict(4, 1);
    probe(6, "R11");
    fill(4, 1, 6, "R11");
    evict(4, 1);
    evict(4, 1);
    probe(6, "R11");
    // R5: four reused evictions saturate at 3, then three declines reach 0
    for (int k = 0; k < 4; k++) begin
      fill(0, 1, 7, "");
      hitl(0, 1, 7, "R2");
      evict(0, 1);
    end
    for (int k = 0; k < 2; k++) begin fill(0, 1, 7, ""); evict(0, 1); end
    probe(7, "R5");
    fill(0, 1, 7, ""); evict(0, 1);
    probe(7, "R5");
    // R7: repeated hits give a single increment at eviction
    fill(4, 2, 9, "R7");
    for (int k = 0; k < 3; k++) hitl(4, 2, 9, "R7");
    probe(9, "R7");
    evict(4, 2);
    for (int k = 0; k < 2; k++) begin fill(4, 2, 9, ""); evict(4, 2); end
    probe(9, "R7");
    // R8: untracked set never trains
    for (int k = 0; k < 3; k++) begin fill(1, 0, 10, "R8"); hitl(1, 0, 10, "R8"); evict(1, 0); end
    probe(10, "R8");
    // R9: aliasing signatures 0x0003 and 0x0018 share counter 3
    fill(0, 2, 'h3, "R9");
    evict(0, 2);
    probe('h18, "R9");
    // R10: same-cycle training and read of one counter
    fill(8, 3, 12, "R10");
    step(1, 0, 1, 0, 12, 1, 8, 3, "R10");
    probe(12, "R10");
    // R12: eviction and fill of one line in the same cycle
    fill(12, 0, 13, "R12");
    hitl(12, 0, 13, "R12");
    step(1, 0, 12, 0, 14, 1, 12, 0, "R12");
    evict(12, 0);
    probe(14, "R12");
    probe(13, "R12");

    // near-exhaustive random stream over all tracked lines
    for (int n = 0; n < 4000; n++) begin
      int st, es;
      st = ($urandom % 2) ? int'($urandom % 4) * 4 : int'($urandom % 16);
      es = ($urandom % 2) ? int'($urandom % 4) * 4 : int'($urandom % 16);
      step(($urandom % 4) != 0, $urandom % 2, st, $urandom % 4, $urandom % 16384,
           ($urandom % 3) == 0, es, $urandom % 4, "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule